// File: doc/BRIEF.md
# Subvector Element Swizzle Unit

This block reorders the scalars inside the short subvectors of a packed vector. The vector sits in a register file of 64-bit registers. Scalars of one width are packed tightly from bit 0 of a base register upward. The vector is made of `vl` groups. Each source group holds `src_len` scalars and each destination group holds `dst_len` scalars. Every destination lane takes its value from the source lane named by that lane's selector. Selectors may repeat a source lane. With `dst_len` set to 1, the unit pulls one chosen scalar out of every group.

A caller sets up the configuration inputs and pulses `start` while the unit is idle. The unit then makes one register-file write per cycle. Each write has byte enables, so the other scalars that share a register are left as they were. When the last write is done, the unit raises `done` for one cycle. If the configuration is illegal, the unit writes nothing and raises `err` together with `done`. The read port is combinational: `rd_data` must return the register named by `rd_idx` in the same cycle.

Top module: `swz_unit`

## Requirements
- R1: For group i in 0..vl-1 and destination lane k in 0..dst_len-1, destination scalar i*dst_len+k receives source scalar i*src_len+sel[k]. Selector for lane k is `lane_sel[2k+1:2k]`.
- R2: `src_len` and `dst_len` are independent, each from 1 to 4. With `dst_len`=1, one source lane is extracted from every group.
- R3: Selectors may repeat a source lane, and the value is copied to every lane that names it.
- R4: `elem_size` codes 0,1,2,3 select 8-, 16-, 32- and 64-bit scalars. Scalar j of a vector lies at bit address j*width counted from bit 0 of its base register. Its register is base + (j*width)/64, modulo the register-file depth, and its offset in that register is (j*width) mod 64.
- R5: Each write asserts `wr_be` only for the bytes of the scalar being written. All other bytes in the register are preserved.
- R6: Writes occur on the cycles directly after the `start` edge, one per cycle, with no gaps, vl*dst_len of them in total. `done` is high for exactly one cycle, on the cycle after the last write.
- R7: A configuration is rejected if a length is outside 1..4, if `vl` exceeds 64, or if a used selector is not below `src_len`. A rejected configuration makes no writes and raises `err` and `done` together on the cycle after `start`.
- R8: With `vl`=0, the unit makes no writes and raises `done`, with `err` low, on the cycle after `start`.
- R9: Out of reset, `done`, `err`, `wr_en` and `busy` are low.
- R10: `start` is ignored while `busy` is high, and the operation in progress completes unchanged.
- R11: Selectors for lanes at or above `dst_len` are ignored and do not make a configuration illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin an operation; sampled while idle |
| vl | input | 7 | Number of groups, 0..64 |
| src_len | input | 3 | Scalars per source group, 1..4 |
| dst_len | input | 3 | Scalars per destination group, 1..4 |
| elem_size | input | 2 | Scalar width code: 0=8, 1=16, 2=32, 3=64 bits |
| lane_sel | input | 8 | Four 2-bit source-lane selectors, lane 0 in the low bits |
| src_base | input | 6 | First register of the source vector |
| dst_base | input | 6 | First register of the destination vector |
| rd_en | output | 1 | Read port active |
| rd_idx | output | 6 | Register being read |
| rd_data | input | 64 | Contents of register `rd_idx`, same cycle |
| wr_en | output | 1 | Write port active |
| wr_idx | output | 6 | Register being written |
| wr_data | output | 64 | Write data, scalar placed at its bit offset |
| wr_be | output | 8 | Byte enables for the write |
| busy | output | 1 | Operation in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Configuration rejected; high with `done` |

## Verification
The assertions assume the register file returns read data in the same cycle, and that the source and destination regions do not overlap. If they overlapped, an early write could change a scalar that a later read depends on. The random stimulus keeps the two regions apart: sources start below register 4 and destinations start at register 32 or above. Group counts are capped by scalar width so that neither region wraps into the other. Selectors in the random runs are drawn below `src_len`. Illegal selectors, illegal lengths and over-long vectors appear only in directed cases.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl #(
  parameter int MAX_VL  = 64,
  parameter int MAX_SUB = 4,
  parameter int RIW     = 6,
  parameter int VLW     = 7,
  parameter int LW      = 3,
  parameter int SELW    = 2,
  parameter int EIW     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [VLW-1:0]          vl,
  input  logic [LW-1:0]           src_len,
  input  logic [LW-1:0]           dst_len,
  input  logic [1:0]              elem_size,
  input  logic [MAX_SUB*SELW-1:0] lane_sel,
  input  logic [RIW-1:0]          src_base,
  input  logic [RIW-1:0]          dst_base,
  output logic                    run,
  output logic                    fin,
  output logic                    err,
  output logic [EIW-1:0]          src_elem,
  output logic [EIW-1:0]          dst_elem,
  output logic [1:0]              esz_q,
  output logic [RIW-1:0]          src_base_q,
  output logic [RIW-1:0]          dst_base_q
);
  import swz_pkg::*;

  st_e                    st_q, st_d;
  logic                   err_q, err_d;
  logic [VLW-1:0]         vl_q;
  logic [LW-1:0]          src_len_q, dst_len_q;
  logic [MAX_SUB*SELW-1:0] sel_q;
  logic [SELW-1:0]        lane_q, lane_d;
  logic [VLW-1:0]         grp_q, grp_d;
  logic [EIW-1:0]         sgrp_q, sgrp_d;
  logic [EIW-1:0]         delem_q, delem_d;
  logic                   cfg_le;
  logic                   cfg_ok;
  logic [SELW-1:0]        sel_lane;

  // configuration capture only when idle
  assign cfg_le = (st_q == ST_IDLE) && start;

  always_comb begin
    cfg_ok = (src_len >= LW'(1)) && (int'(src_len) <= MAX_SUB) &&
             (dst_len >= LW'(1)) && (int'(dst_len) <= MAX_SUB) &&
             (int'(vl) <= MAX_VL);
    for (int k = 0; k < MAX_SUB; k++) begin
      if ((k < int'(dst_len)) && (LW'(lane_sel[k*SELW +: SELW]) >= src_len)) begin
        cfg_ok = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q       <= '0;
      src_len_q  <= '0;
      dst_len_q  <= '0;
      esz_q      <= '0;
      sel_q      <= '0;
      src_base_q <= '0;
      dst_base_q <= '0;
    end else if (cfg_le) begin
      vl_q       <= vl;
      src_len_q  <= src_len;
      dst_len_q  <= dst_len;
      esz_q      <= elem_size;
      sel_q      <= lane_sel;
      src_base_q <= src_base;
      dst_base_q <= dst_base;
    end
  end

  always_comb begin
    st_d    = st_q;
    err_d   = err_q;
    lane_d  = lane_q;
    grp_d   = grp_q;
    sgrp_d  = sgrp_q;
    delem_d = delem_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          lane_d  = '0;
          grp_d   = '0;
          sgrp_d  = '0;
          delem_d = '0;
          if (!cfg_ok) begin
            err_d = 1'b1;
            st_d  = ST_FIN;
          end else if (vl == '0) begin
            st_d = ST_FIN;
          end else begin
            st_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        delem_d = delem_q + EIW'(1);
        if (LW'(lane_q) == (dst_len_q - LW'(1))) begin
          lane_d = '0;
          grp_d  = grp_q + VLW'(1);
          sgrp_d = sgrp_q + EIW'(src_len_q);
          if (grp_q == (vl_q - VLW'(1))) begin
            st_d = ST_FIN;
          end
        end else begin
          lane_d = lane_q + SELW'(1);
        end
      end
      ST_FIN: begin
        st_d  = ST_IDLE;
        err_d = 1'b0;
      end
      default: begin
        st_d  = ST_IDLE;
        err_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      err_q   <= 1'b0;
      lane_q  <= '0;
      grp_q   <= '0;
      sgrp_q  <= '0;
      delem_q <= '0;
    end else begin
      st_q    <= st_d;
      err_q   <= err_d;
      lane_q  <= lane_d;
      grp_q   <= grp_d;
      sgrp_q  <= sgrp_d;
      delem_q <= delem_d;
    end
  end

  assign sel_lane = sel_q[lane_q*SELW +: SELW];
  assign src_elem = sgrp_q + EIW'(sel_lane);
  assign dst_elem = delem_q;
  assign run      = (st_q == ST_RUN);
  assign fin      = (st_q == ST_FIN);
  assign err      = fin && err_q;

  // write counter kept only for the completion-count check
  logic [EIW:0] wr_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt_q <= '0;
    end else if (cfg_le) begin
      wr_cnt_q <= '0;
    end else if (run) begin
      wr_cnt_q <= wr_cnt_q + (EIW+1)'(1);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin); // R6

  AST_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !err_q) |-> (wr_cnt_q == ((EIW+1)'(vl_q) * (EIW+1)'(dst_len_q)))); // R6

  AST_ERR_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start)); // R7

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (LW'(sel_lane) < src_len_q)); // R7

  AST_VL0_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && start && (vl == '0)) |=> !run); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_IDLE) && start) |=> ($stable(vl_q) && $stable(sel_q) && $stable(dst_len_q))); // R10

endmodule

// File: rtl/swz_addr.sv
module swz_addr #(
  parameter int REG_W = 64,
  parameter int RIW   = 6,
  parameter int EIW   = 8,
  parameter int OFFW  = 6
) (
  input  logic [EIW-1:0]  elem,
  input  logic [1:0]      esz,
  input  logic [RIW-1:0]  base,
  output logic [RIW-1:0]  ridx,
  output logic [OFFW-1:0] boff
);
  // bit address wide enough for the largest index at 64-bit scalars
  localparam int BAW = EIW + 6;

  logic [BAW-1:0] bitaddr;
  logic [BAW-1:0] reg_off;

  always_comb begin
    bitaddr = (BAW'(elem) << esz) << 3;
    reg_off = bitaddr >> OFFW;
  end

  assign ridx = base + RIW'(reg_off);
  assign boff = bitaddr[OFFW-1:0];

endmodule

// File: rtl/swz_lane.sv
module swz_lane #(
  parameter int REG_W = 64,
  parameter int OFFW  = 6,
  parameter int BEW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [REG_W-1:0] rd_data,
  input  logic [OFFW-1:0]  src_off,
  input  logic [OFFW-1:0]  dst_off,
  input  logic [1:0]       esz,
  output logic [REG_W-1:0] wr_data,
  output logic [BEW-1:0]   wr_be
);
  logic [REG_W-1:0] mask;
  logic [REG_W-1:0] pick;
  logic [OFFW-4:0]  obyte;
  logic [3:0]       nbytes;
  int               ebits;

  always_comb begin
    ebits  = 8 << esz;
    nbytes = 4'(1) << esz;
    if (ebits >= REG_W) begin
      mask = '1;
    end else begin
      mask = (REG_W'(1) << ebits) - REG_W'(1);
    end
    pick    = (rd_data >> src_off) & mask;
    wr_data = pick << dst_off;
  end

  assign obyte = dst_off[OFFW-1:3];

  for (genvar g = 0; g < BEW; g++) begin : g_be
    assign wr_be[g] = valid && (g >= int'(obyte)) && (g < (int'(obyte) + int'(nbytes)));
  end

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (((int'(dst_off) % ebits) == 0) && ((int'(src_off) % ebits) == 0))); // R4

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones(wr_be) == int'(nbytes))); // R5

endmodule

// File: rtl/swz_unit.sv
module swz_unit #(
  parameter int REG_W    = 64,
  parameter int RF_DEPTH = 64,
  parameter int MAX_VL   = 64,
  parameter int MAX_SUB  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [$clog2(MAX_VL+1)-1:0]           vl,
  input  logic [$clog2(MAX_SUB+1)-1:0]          src_len,
  input  logic [$clog2(MAX_SUB+1)-1:0]          dst_len,
  input  logic [1:0]                            elem_size,
  input  logic [MAX_SUB*$clog2(MAX_SUB)-1:0]    lane_sel,
  input  logic [$clog2(RF_DEPTH)-1:0]           src_base,
  input  logic [$clog2(RF_DEPTH)-1:0]           dst_base,
  output logic                                  rd_en,
  output logic [$clog2(RF_DEPTH)-1:0]           rd_idx,
  input  logic [REG_W-1:0]                      rd_data,
  output logic                                  wr_en,
  output logic [$clog2(RF_DEPTH)-1:0]           wr_idx,
  output logic [REG_W-1:0]                      wr_data,
  output logic [REG_W/8-1:0]                    wr_be,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  err
);
  localparam int RIW  = $clog2(RF_DEPTH);
  localparam int VLW  = $clog2(MAX_VL+1);
  localparam int LW   = $clog2(MAX_SUB+1);
  localparam int SELW = $clog2(MAX_SUB);
  localparam int EIW  = $clog2(MAX_VL*MAX_SUB);
  localparam int OFFW = $clog2(REG_W);
  localparam int BEW  = REG_W/8;

  logic           run, fin;
  logic [EIW-1:0] src_elem, dst_elem;
  logic [1:0]     esz_q;
  logic [RIW-1:0] src_base_q, dst_base_q;
  logic [OFFW-1:0] src_off, dst_off;

  swz_ctrl #(
    .MAX_VL(MAX_VL), .MAX_SUB(MAX_SUB), .RIW(RIW), .VLW(VLW),
    .LW(LW), .SELW(SELW), .EIW(EIW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_len(src_len), .dst_len(dst_len), .elem_size(elem_size),
    .lane_sel(lane_sel), .src_base(src_base), .dst_base(dst_base),
    .run(run), .fin(fin), .err(err),
    .src_elem(src_elem), .dst_elem(dst_elem), .esz_q(esz_q),
    .src_base_q(src_base_q), .dst_base_q(dst_base_q)
  );

  swz_addr #(.REG_W(REG_W), .RIW(RIW), .EIW(EIW), .OFFW(OFFW)) u_src_addr (
    .elem(src_elem), .esz(esz_q), .base(src_base_q),
    .ridx(rd_idx), .boff(src_off)
  );

  swz_addr #(.REG_W(REG_W), .RIW(RIW), .EIW(EIW), .OFFW(OFFW)) u_dst_addr (
    .elem(dst_elem), .esz(esz_q), .base(dst_base_q),
    .ridx(wr_idx), .boff(dst_off)
  );

  swz_lane #(.REG_W(REG_W), .OFFW(OFFW), .BEW(BEW)) u_lane (
    .clk(clk), .rst_n(rst_n), .valid(run), .rd_data(rd_data),
    .src_off(src_off), .dst_off(dst_off), .esz(esz_q),
    .wr_data(wr_data), .wr_be(wr_be)
  );

  assign rd_en = run;
  assign wr_en = run;
  assign busy  = run || fin;
  assign done  = fin;

  AST_NO_WR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !wr_en); // R6

endmodule

// File: tb/swz_unit_tb.sv
module swz_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [6:0]  vl_i;
  logic [2:0]  sl_i, dl_i;
  logic [1:0]  esz_i;
  logic [7:0]  sel_i;
  logic [5:0]  sb_i, db_i;
  logic        rd_en;
  logic [5:0]  rd_idx;
  logic [63:0] rd_data;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;
  logic        busy, done, err;

  logic [63:0] rf     [0:63];
  logic [63:0] exp_rf [0:63];

  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign rd_data = rf[rd_idx];

  swz_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl_i),
    .src_len(sl_i), .dst_len(dl_i), .elem_size(esz_i), .lane_sel(sel_i),
    .src_base(sb_i), .dst_base(db_i),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit cfg_legal(input int vl, input int sl, input int dl, input logic [7:0] sel);
    if (sl < 1 || sl > 4 || dl < 1 || dl > 4 || vl > 64) return 1'b0;
    for (int k = 0; k < dl; k++) begin
      if (int'(sel[2*k +: 2]) >= sl) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [63:0] wmask(input int w);
    return (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  task automatic build_expected(input int vl, input int sl, input int dl, input int esz,
                                input logic [7:0] sel, input int sb, input int db, input bit legal);
    int w;
    for (int r = 0; r < 64; r++) exp_rf[r] = rf[r];
    if (!legal) return;
    w = 8 << esz;
    for (int i = 0; i < vl; i++) begin
      for (int k = 0; k < dl; k++) begin
        int s_idx, d_idx, sbit, dbit, sr, dr, so, dof;
        logic [63:0] v;
        s_idx = i*sl + int'(sel[2*k +: 2]);
        d_idx = i*dl + k;
        sbit = s_idx * w;
        dbit = d_idx * w;
        sr   = (sb + sbit/64) % 64;
        so   = sbit % 64;
        dr   = (db + dbit/64) % 64;
        dof  = dbit % 64;
        v = (rf[sr] >> so) & wmask(w);
        exp_rf[dr] = (exp_rf[dr] & ~(wmask(w) << dof)) | (v << dof);
      end
    end
  endtask

  task automatic run_op(input int vl, input int sl, input int dl, input int esz,
                        input logic [7:0] sel, input int sb, input int db,
                        input string req, input bit poke);
    bit legal;
    int exp_n, nw, cyc, done_cyc, mism;
    bit gaps, got_err;
    legal = cfg_legal(vl, sl, dl, sel);
    exp_n = legal ? vl*dl : 0;
    for (int r = 0; r < 64; r++) rf[r] = {$urandom, $urandom};
    build_expected(vl, sl, dl, esz, sel, sb, db, legal);
    @(negedge clk);
    vl_i = 7'(vl); sl_i = 3'(sl); dl_i = 3'(dl); esz_i = 2'(esz);
    sel_i = sel; sb_i = 6'(sb); db_i = 6'(db);
    start = 1'b1;
    nw = 0; cyc = 0; done_cyc = -1; gaps = 1'b0; got_err = 1'b0;
    while (done_cyc < 0 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (wr_en) begin
        nw++;
        if (nw != cyc) gaps = 1'b1;
        for (int b = 0; b < 8; b++) begin
          if (wr_be[b]) rf[wr_idx][b*8 +: 8] = wr_data[b*8 +: 8];
        end
      end
      if (done) begin
        done_cyc = cyc;
        got_err  = err;
      end
      if (cyc == 1) start = 1'b0;
      if (poke && cyc == 2) begin
        start = 1'b1; vl_i = 7'd1; sel_i = 8'h00; dl_i = 3'd1; db_i = 6'd0;
      end
      if (poke && cyc == 3) start = 1'b0;
    end
    chk(nw == exp_n, {req, " R6 write count"}, nw, exp_n);
    chk(done_cyc == exp_n + 1, {req, " R6 done cycle"}, done_cyc, exp_n + 1);
    chk(!gaps, {req, " R6 back-to-back writes"}, gaps, 0);
    chk(got_err == !legal, {req, " R7 err flag"}, got_err, !legal);
    mism = 0;
    for (int r = 0; r < 64; r++) if (rf[r] !== exp_rf[r]) mism++;
    chk(mism == 0, {req, " register contents (R1 R4 R5)"}, mism, 0);
    @(negedge clk);
    chk(!done && !busy, {req, " R6 done single pulse"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0;
    vl_i = '0; sl_i = 3'd1; dl_i = 3'd1; esz_i = '0; sel_i = '0; sb_i = '0; db_i = '0;
    for (int r = 0; r < 64; r++) rf[r] = '0;
    repeat (3) @(negedge clk);
    chk(!done && !err && !wr_en && !busy, "R9 reset state", {done, err, wr_en, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !err && !wr_en && !busy, "R9 idle after reset", {done, err, wr_en, busy}, 0);

    // R1 R3: lane 0 twice, then lanes 2 and 1, bytes, five groups
    run_op(5, 3, 4, 0, {2'd1, 2'd2, 2'd0, 2'd0}, 2, 40, "R1 R3 repeat-lane", 1'b0);
    // R2: extraction of lane 2 from 4-scalar groups of 32 bits
    run_op(5, 4, 1, 2, {2'd0, 2'd0, 2'd0, 2'd2}, 0, 33, "R2 extract", 1'b0);
    // R11: upper lanes hold out-of-range selectors but are unused
    run_op(6, 2, 1, 1, {2'd3, 2'd3, 2'd3, 2'd1}, 1, 34, "R11 unused lanes", 1'b0);
    // R4: 64-bit scalars, swap pairs
    run_op(4, 2, 2, 3, {2'd0, 2'd0, 2'd0, 2'd1}, 3, 36, "R4 wide swap", 1'b0);
    // R4 R5: 16-bit scalars, 3 -> 2 with partial registers
    run_op(7, 3, 2, 1, {2'd0, 2'd0, 2'd0, 2'd2}, 0, 32, "R4 R5 halfword", 1'b0);
    // R8: zero-length vector
    run_op(0, 3, 3, 0, {2'd0, 2'd2, 2'd1, 2'd0}, 0, 32, "R8 empty", 1'b0);
    // R7: selector beyond source length on a used lane
    run_op(4, 2, 3, 0, {2'd0, 2'd2, 2'd1, 2'd0}, 0, 32, "R7 bad selector", 1'b0);
    // R7: zero destination length, oversize source length, too many groups
    run_op(4, 2, 0, 0, 8'h00, 0, 32, "R7 zero length", 1'b0);
    run_op(4, 5, 2, 0, 8'h00, 0, 32, "R7 long length", 1'b0);
    run_op(65, 2, 2, 0, 8'h00, 0, 32, "R7 vl too big", 1'b0);
    // R6: largest vector in bytes
    run_op(64, 4, 4, 0, {2'd0, 2'd1, 2'd2, 2'd3}, 0, 32, "R6 full length", 1'b0);
    // R10: start pulsed while busy
    run_op(6, 4, 3, 2, {2'd0, 2'd3, 2'd3, 2'd1}, 0, 32, "R10 start while busy", 1'b1);

    for (int n = 0; n < 40; n++) begin
      int sl, dl, esz, vl, lim;
      logic [7:0] sel;
      sl  = 1 + int'($urandom % 4);
      dl  = 1 + int'($urandom % 4);
      esz = int'($urandom % 4);
      lim = (esz == 3) ? 7 : 12;
      vl  = 1 + int'($urandom % lim);
      for (int k = 0; k < 4; k++) sel[2*k +: 2] = 2'($urandom % sl);
      run_op(vl, sl, dl, esz, sel, int'($urandom % 4), 32 + int'($urandom % 4),
             "R1 R2 random", 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule